// File: doc/BRIEF.md
# Buffered PWM Timer with Linked Channel Pairs

The block is a free-running up-counter with a programmable modulo value and a set of compare channels grouped into even/odd pairs. Each pair drives one PWM pin. The pin goes high at the period boundary, which is the tick on which the counter wraps from the modulo value to zero. It goes low on the compare match of the channel that currently owns the pulse width. In single mode, only the even channel sets the width. In buffered mode, the two compare registers of a pair take turns. Software rewrites the idle register, and the new width is applied at the next wrap. A period that is already running is never cut short by a rewrite.

Each channel has a flag that is set on its compare match. The flag is steered to a CPU interrupt line or to a DMA request line, depending on two control bits. A DMA request is a level. It stays asserted until the DMA engine pulses the acknowledge for that channel, and that pulse clears the flag. There is no other back-pressure at the block's edge. The register port is a plain single-cycle write/read port with a combinational read path. A read only has a side effect on flags: a read that returns a set flag arms it to be cleared by the next write.

The counter advances only on cycles where the external prescaled enable `tick` is high and the halt bit is clear.

Top module: `pwm_timer_top`

## Requirements
- R1: On each cycle where `tick` is 1 and the halt bit (TCTRL bit 0, 1 after reset) is 0, the counter steps by one. From the modulo value it steps to 0. While halt is 1, the counter holds its value.
- R2: Writing 1 to TCTRL bit 1 forces the counter to 0 on the next edge and leaves the modulo register unchanged. The bit always reads 0.
- R3: The overflow flag (TCTRL bit 7) is set when the counter wraps. `ovf_irq` is 1 exactly while that flag and the overflow enable (TCTRL bit 2) are both 1.
- R4: A flag (TCTRL bit 7, or channel control bit 7) is cleared by a write of 0 to that bit only if a read with `reg_rd` returned the flag set since the last write to that register. A write of 0 with no such read leaves the flag set.
- R5: Single mode (channel control bit 2 of the even channel, with bit 3 clear) and overflow-set (bit 4) make the pin high from the wrap for compare+1 counts of each period. Only the even channel's compare register sets this width.
- R6: Buffered mode (even channel control bit 3) starts with the even register in control. A write to the idle register of the pair takes effect only at the next wrap, at which point control swaps to it.
- R7: When bits 2 and 3 are both set, the pair behaves as in buffered mode.
- R8: With overflow-set (bit 4) clear, the wrap does not raise the pin, and the pin stays at 0% duty.
- R9: With the max-duty bit (bit 5) set on the even channel of an enabled pair, the pin stays at 100% duty.
- R10: A channel's flag (control bit 7) is set on every compare match of that channel, whatever its routing bits are.
- R11: With interrupt enable (bit 0) = 1 and DMA select (bit 1) = 0, a set flag drives `ch_irq`. With bit 0 = 1 and bit 1 = 1, a set flag drives `ch_dma_req` instead. With bit 0 = 0, a set flag drives neither.
- R12: `ch_dma_req` stays asserted until the matching `ch_dma_ack` bit is pulsed. That pulse clears the channel flag, so the request drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | ADDR_W | Register address: 0 TCTRL, 1 modulo, 2 counter, 4+i channel i control, 4+NCH+i channel i compare |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, combinational from `reg_addr` |
| pwm_out | output | NCH/2 | One PWM pin per channel pair |
| ovf_irq | output | 1 | Overflow interrupt request |
| ch_irq | output | NCH | Per-channel CPU interrupt request |
| ch_dma_req | output | NCH | Per-channel DMA request level |
| ch_dma_ack | input | NCH | Per-channel DMA acknowledge pulse |

## Verification
The bench builds the block with its defaults: a 16-bit counter and four channels, which gives two pairs. It programs a modulo of 9, so each period lasts ten ticks. Duty cycles can then be measured over two-period windows without lining up with the edges. The short period also brings the buffered swap into reach. The bench polls the counter to find the wrap, rewrites the idle register inside one period, and shows that the old width holds in that period and the new width appears in the next. The four channels cover all three routing codes and the DMA acknowledge at the same time.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  // Channel control register layout, bit 7 down to bit 0.
  typedef struct packed {
    logic flag;
    logic spare;
    logic max_duty;
    logic tog_ovf;
    logic mode_buf;
    logic mode_single;
    logic dma_sel;
    logic ie;
  } ch_ctl_t;

  localparam int CTL_W     = 8;
  localparam int A_TCTRL   = 0;
  localparam int A_MOD     = 1;
  localparam int A_CNT     = 2;
  localparam int A_CH_BASE = 4;

  localparam int TC_HALT = 0;
  localparam int TC_ZERO = 1;
  localparam int TC_IE   = 2;
  localparam int TC_FLAG = 7;
endpackage

// File: rtl/pwmt_timebase.sv
module pwmt_timebase
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_we,
  input  logic             ctrl_rd,
  input  logic [CTL_W-1:0] ctrl_wdata,
  input  logic             mod_we,
  input  logic [CNT_W-1:0] mod_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] mod,
  output logic             run_tick,
  output logic             ovf_evt,
  output logic             halt,
  output logic             ovf_ie,
  output logic             ovf_flag
);
  logic zero_req;
  logic armed_q;

  assign zero_req = ctrl_we & ctrl_wdata[TC_ZERO];
  assign run_tick = tick & ~halt;
  assign ovf_evt  = run_tick & (cnt == mod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (zero_req || ovf_evt) begin
      cnt <= '0;
    end else if (run_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod <= '1;
    end else if (mod_we) begin
      mod <= mod_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt   <= 1'b1;
      ovf_ie <= 1'b0;
    end else if (ctrl_we) begin
      halt   <= ctrl_wdata[TC_HALT];
      ovf_ie <= ctrl_wdata[TC_IE];
    end
  end

  // A read that returns the flag set arms it; any write disarms it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (ctrl_we) begin
      armed_q <= 1'b0;
    end else if (ctrl_rd && ovf_flag) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (ovf_evt) begin
      ovf_flag <= 1'b1;
    end else if (ctrl_we && !ctrl_wdata[TC_FLAG] && armed_q) begin
      ovf_flag <= 1'b0;
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !zero_req) |=> $stable(cnt)); // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0)); // R1
  AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R3
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(ctrl_we)); // R4
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_rd,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run_tick,
  input  logic             dma_ack,
  output ch_ctl_t          ctl,
  output logic [CNT_W-1:0] cmp,
  output logic             match_evt,
  output logic             irq,
  output logic             dma_req
);
  logic [CTL_W-2:0] cfg_q;
  logic             flag_q;
  logic             armed_q;

  assign ctl       = ch_ctl_t'({flag_q, cfg_q});
  assign match_evt = run_tick & (cnt == cmp);
  assign irq       = flag_q & ctl.ie & ~ctl.dma_sel;
  assign dma_req   = flag_q & ctl.ie & ctl.dma_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ctl_we) begin
      cfg_q <= ctl_wdata[CTL_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (cmp_we) begin
      cmp <= cmp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (ctl_we) begin
      armed_q <= 1'b0;
    end else if (ctl_rd && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (match_evt) begin
      flag_q <= 1'b1;
    end else if (dma_req && dma_ack) begin
      flag_q <= 1'b0;
    end else if (ctl_we && !ctl_wdata[CTL_W-1] && armed_q) begin
      flag_q <= 1'b0;
    end
  end

  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> ctl.flag); // R10
  AST_DMA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && !ctl_we) |=> dma_req); // R12
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !match_evt) |=> !dma_req); // R12
  AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({irq, dma_req}) <= 1); // R11
endmodule

// File: rtl/pwmt_pair.sv
module pwmt_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_buf,
  input  logic mode_single,
  input  logic tog_ovf,
  input  logic max_duty,
  input  logic match_even,
  input  logic match_odd,
  input  logic cmp_we_even,
  input  logic cmp_we_odd,
  input  logic ovf_evt,
  output logic pwm
);
  logic sel_q;      // 0: even register owns the width, 1: odd register
  logic pending_q;  // idle register rewritten since the last swap
  logic level_q;
  logic active;
  logic act_match;
  logic idle_write;

  assign active     = mode_buf | mode_single;
  assign act_match  = (mode_buf && sel_q) ? match_odd : match_even;
  assign idle_write = sel_q ? cmp_we_even : cmp_we_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      pending_q <= 1'b0;
    end else if (!mode_buf) begin
      sel_q     <= 1'b0;
      pending_q <= 1'b0;
    end else if (ovf_evt && pending_q) begin
      sel_q     <= ~sel_q;
      pending_q <= 1'b0;
    end else if (idle_write) begin
      pending_q <= 1'b1;
    end
  end

  // The period boundary wins over a compare match on the same tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else if (!active) begin
      level_q <= 1'b0;
    end else if (ovf_evt && tog_ovf) begin
      level_q <= 1'b1;
    end else if (act_match) begin
      level_q <= 1'b0;
    end
  end

  assign pwm = active & (max_duty | level_q);

  AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> ($past(ovf_evt) || !$past(mode_buf))); // R6
  AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm) && !max_duty) |-> $past(ovf_evt)); // R8
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NCH/2-1:0]  pwm_out,
  output logic              ovf_irq,
  output logic [NCH-1:0]    ch_irq,
  output logic [NCH-1:0]    ch_dma_req,
  input  logic [NCH-1:0]    ch_dma_ack
);
  localparam int NPAIR    = NCH / 2;
  localparam int CMP_BASE = A_CH_BASE + NCH;

  logic [CNT_W-1:0] cnt, mod;
  logic             run_tick, ovf_evt, halt, ovf_ie, ovf_flag;
  logic             ctrl_we, ctrl_rd, mod_we;

  ch_ctl_t          ch_ctl [NCH];
  logic [CNT_W-1:0] ch_cmp [NCH];
  logic [NCH-1:0]   ch_match, ch_ctl_we, ch_ctl_rd, ch_cmp_we;

  assign ctrl_we = reg_wr & (reg_addr == ADDR_W'(A_TCTRL));
  assign ctrl_rd = reg_rd & (reg_addr == ADDR_W'(A_TCTRL));
  assign mod_we  = reg_wr & (reg_addr == ADDR_W'(A_MOD));

  pwmt_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ctrl_we    (ctrl_we),
    .ctrl_rd    (ctrl_rd),
    .ctrl_wdata (reg_wdata[CTL_W-1:0]),
    .mod_we     (mod_we),
    .mod_wdata  (reg_wdata),
    .cnt        (cnt),
    .mod        (mod),
    .run_tick   (run_tick),
    .ovf_evt    (ovf_evt),
    .halt       (halt),
    .ovf_ie     (ovf_ie),
    .ovf_flag   (ovf_flag)
  );

  assign ovf_irq = ovf_flag & ovf_ie;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_ctl_we[i] = reg_wr & (reg_addr == ADDR_W'(A_CH_BASE + i));
    assign ch_ctl_rd[i] = reg_rd & (reg_addr == ADDR_W'(A_CH_BASE + i));
    assign ch_cmp_we[i] = reg_wr & (reg_addr == ADDR_W'(CMP_BASE + i));

    pwmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ch_ctl_we[i]),
      .ctl_rd    (ch_ctl_rd[i]),
      .ctl_wdata (reg_wdata[CTL_W-1:0]),
      .cmp_we    (ch_cmp_we[i]),
      .cmp_wdata (reg_wdata),
      .cnt       (cnt),
      .run_tick  (run_tick),
      .dma_ack   (ch_dma_ack[i]),
      .ctl       (ch_ctl[i]),
      .cmp       (ch_cmp[i]),
      .match_evt (ch_match[i]),
      .irq       (ch_irq[i]),
      .dma_req   (ch_dma_req[i])
    );
  end

  // The even channel's control register governs the pair's pin.
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwmt_pair u_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_buf    (ch_ctl[2*p].mode_buf),
      .mode_single (ch_ctl[2*p].mode_single),
      .tog_ovf     (ch_ctl[2*p].tog_ovf),
      .max_duty    (ch_ctl[2*p].max_duty),
      .match_even  (ch_match[2*p]),
      .match_odd   (ch_match[2*p+1]),
      .cmp_we_even (ch_cmp_we[2*p]),
      .cmp_we_odd  (ch_cmp_we[2*p+1]),
      .ovf_evt     (ovf_evt),
      .pwm         (pwm_out[p])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_TCTRL)) begin
      reg_rdata = CNT_W'({ovf_flag, 4'b0000, ovf_ie, 1'b0, halt});
    end else if (reg_addr == ADDR_W'(A_MOD)) begin
      reg_rdata = mod;
    end else if (reg_addr == ADDR_W'(A_CNT)) begin
      reg_rdata = cnt;
    end
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == ADDR_W'(A_CH_BASE + i)) reg_rdata = CNT_W'(ch_ctl[i]);
      if (reg_addr == ADDR_W'(CMP_BASE + i))  reg_rdata = ch_cmp[i];
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (reg_rdata[TC_FLAG] || reg_addr != ADDR_W'(A_TCTRL))); // R3
endmodule

// File: tb/pwm_timer_top_tb.sv
module pwm_timer_top_tb_top;
  localparam int CW = 16;
  localparam int NC = 4;
  localparam logic [3:0] AT = 4'd0, AM = 4'd1, AC = 4'd2;
  localparam logic [3:0] CTL0 = 4'd4, CTL1 = 4'd5, CTL2 = 4'd6;
  localparam logic [3:0] CMP0 = 4'd8, CMP1 = 4'd9, CMP2 = 4'd10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  logic [NC/2-1:0] pwm_out;
  logic          ovf_irq;
  logic [NC-1:0] ch_irq, ch_dma_req;
  logic [NC-1:0] ch_dma_ack = '0;

  pwm_timer_top #(.CNT_W(CW), .NCH(NC), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .ovf_irq(ovf_irq), .ch_irq(ch_irq),
    .ch_dma_req(ch_dma_req), .ch_dma_ack(ch_dma_ack)
  );

  always #5 clk = ~clk;

  int n_checks = 0, n_err = 0;
  bit done = 0;

  typedef struct { string req; int exp; } exp_t;
  typedef struct { string req; int win; int exp; } win_t;
  exp_t exp_q[$];
  win_t win_q[$];
  int   win_pend = 0;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  // Scoreboard: expectation pushed by the driver, popped on observation.
  task automatic observe(string what, int act);
    exp_t e;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_err++;
      $display("FAIL %s: actual %0d expected <none>", what, act);
    end else begin
      e = exp_q.pop_front();
      if (act != e.exp) begin
        n_err++;
        $display("FAIL %s %s: actual %0d expected %0d", e.req, what, act, e.exp);
      end
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    exp_q.push_back('{req, exp});
    observe(what, act);
  endtask

  // Monitor: counts high cycles of pwm_out[0] over each queued window.
  initial begin
    forever begin
      win_t w;
      int hi;
      wait (win_pend > 0);
      w = win_q[0];
      hi = 0;
      for (int k = 0; k < w.win; k++) begin
        @(negedge clk);
        hi += int'(pwm_out[0]);
      end
      void'(win_q.pop_front());
      exp_q.push_back('{w.req, w.exp});
      observe("pwm high cycles", hi);
      win_pend--;
    end
  end

  task automatic expect_duty(string req, int win, int exp);
    win_q.push_back('{req, win, exp});
    win_pend++;
    wait (win_pend == 0);
  endtask

  task automatic wr(logic [3:0] a, logic [CW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [CW-1:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [CW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cnt(int v);
    logic [CW-1:0] c;
    do begin
      @(negedge clk);
      peek(AC, c);
    end while (int'(c) != v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog (all): actual timeout expected completion");
    summary();
  end

  initial begin
    logic [CW-1:0] a, b, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R1", "reset pwm", int'(pwm_out), 0);
    chk("R11", "reset irq/dma", int'({ch_irq, ch_dma_req, ovf_irq}), 0);
    peek(AC, d); chk("R1", "reset count", int'(d), 0);
    peek(AT, d); chk("R1", "reset tctrl (halt=1)", int'(d), 1);

    // Single mode, even width 3 -> 4 high of 10
    wr(AM, 16'd9);
    wr(CTL0, 16'h14);
    wr(CMP0, 16'd3);
    wr(CMP1, 16'd6);
    wr(AT, 16'h04);
    repeat (30) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      peek(AC, a); @(negedge clk); peek(AC, b);
      chk("R1", "count step", int'(b), (a == 9) ? 0 : int'(a) + 1);
    end
    expect_duty("R5", 20, 8);
    wr(CMP1, 16'd8);
    repeat (20) @(negedge clk);
    expect_duty("R5 odd ignored", 20, 8);

    peek(AT, d);
    chk("R3", "ovf flag after wrap", int'(d[7]), 1);
    chk("R3", "ovf_irq", int'(ovf_irq), 1);

    // Buffered mode
    wr(CTL0, 16'h18);
    repeat (20) @(negedge clk);
    expect_duty("R6 even first", 20, 8);
    wait_cnt(0);
    wr(CMP1, 16'd6);
    wait_cnt(5);
    chk("R6", "pin in same period", int'(pwm_out[0]), 0);
    wait_cnt(0);
    wait_cnt(5);
    chk("R6", "pin next period", int'(pwm_out[0]), 1);
    expect_duty("R6 odd width", 20, 14);
    wr(CMP0, 16'd1);
    repeat (20) @(negedge clk);
    expect_duty("R6 swap back", 20, 4);

    // Both mode bits: buffered wins
    wr(CTL0, 16'h1C);
    wr(CMP1, 16'd4);
    repeat (20) @(negedge clk);
    expect_duty("R7", 20, 10);

    // 0% and 100%
    wr(CTL0, 16'h08);
    repeat (20) @(negedge clk);
    expect_duty("R8", 20, 0);
    wr(CTL0, 16'h28);
    expect_duty("R9", 20, 20);

    // Routing
    wr(CTL0, 16'h29);
    wr(CTL1, 16'h03);
    wr(CTL2, 16'h00);
    wr(CMP2, 16'd2);
    repeat (20) @(negedge clk);
    wr(AT, 16'h85);
    chk("R11", "ch0 irq", int'(ch_irq[0]), 1);
    chk("R11", "ch0 dma", int'(ch_dma_req[0]), 0);
    chk("R11", "ch1 dma", int'(ch_dma_req[1]), 1);
    chk("R11", "ch1 irq", int'(ch_irq[1]), 0);
    peek(CTL2, d); chk("R10", "ch2 flag", int'(d[7]), 1);
    chk("R11", "ch2 none", int'({ch_irq[2], ch_dma_req[2]}), 0);

    peek(AC, a); repeat (5) @(negedge clk); peek(AC, b);
    chk("R1", "halted count stable", int'(b), int'(a));

    // DMA acknowledge
    @(negedge clk);
    chk("R12", "dma held", int'(ch_dma_req[1]), 1);
    ch_dma_ack = 4'b0010;
    @(negedge clk);
    ch_dma_ack = '0;
    chk("R12", "dma dropped", int'(ch_dma_req[1]), 0);
    peek(CTL1, d); chk("R12", "ch1 flag cleared", int'(d[7]), 0);

    // Flag clear protocol
    wr(AT, 16'h05);
    peek(AT, d); chk("R4", "unarmed write keeps flag", int'(d[7]), 1);
    chk("R3", "irq while flag", int'(ovf_irq), 1);
    rd(AT, d);
    wr(AT, 16'h05);
    peek(AT, d); chk("R4", "armed write clears flag", int'(d[7]), 0);
    chk("R3", "irq after clear", int'(ovf_irq), 0);
    rd(CTL0, d);
    wr(CTL0, 16'h29);
    chk("R4", "ch0 irq after clear", int'(ch_irq[0]), 0);

    // Counter zero bit
    wr(AT, 16'h04);
    wait_cnt(5);
    wr(AT, 16'h03);
    peek(AC, d); chk("R2", "count zeroed", int'(d), 0);
    peek(AM, d); chk("R2", "modulo kept", int'(d), 9);
    peek(AT, d); chk("R2", "zero bit reads 0", int'(d[1]), 0);

    summary();
  end
endmodule